// File: doc/BRIEF.md
# Gated Prescaled Period Timer

A counter-based interval timer that advances on ticks taken from one of three sources: every cycle of the block clock, the block clock qualified by a gate input, or rising edges of an external clock input. A selectable prescaler divides the chosen source by 1, 8, 64 or 256. Each prescaled tick either advances the counter or, when the counter already equals the period register, returns it to zero. A sticky event flag records period matches. In gated mode it instead records the gate's falling edge, so the block can measure how long a pulse lasts.

Software drives the block through a single write port. The port selects one of three registers (control, counter, period) and one of four write operations: replace, clear bits, set bits or invert bits. All three registers are always visible on output ports. External clock edges are detected either behind a multi-flop synchroniser or straight from the sampled input.

Top module: `prd_timer`

## Requirements
- R1: After reset the control, counter and period outputs and the event flag are all zero, which means the timer is off, uses the internal source and divides by 1.
- R2: While on and not gated, each prescaled tick raises the counter by one. A tick that finds the counter equal to the period sets the counter to zero and sets the event flag.
- R3: Control bits [5:4] select the divide ratio: 00 gives 1, 01 gives 8, 10 gives 64 and 11 gives 256 source ticks per counter tick.
- R4: In gated mode (bit1=0, bit2=1) the counter advances only on cycles where gate_in is high. A period match still returns the counter to zero but does not set the flag. The flag is set one cycle after the first clock edge at which gate_in is seen low after being high.
- R5: With bit1=1 and bit3=1, each rising edge of ext_clk produces one tick once it has passed the synchroniser, and gate_in has no effect.
- R6: With bit1=1 and bit3=0, a tick is taken at the first clock edge where ext_clk is high after having been low at the previous edge.
- R7: While bit0 (on) is clear, the counter holds its value and the prescaler stays at its start.
- R8: wr_sel 0, 1 and 2 address control, counter and period. wr_op 00 replaces the register, 01 clears the bits written as 1, 10 sets them, and 11 inverts them. wr_sel 3 changes nothing. The period changes only through writes.
- R9: Any write to the counter or control register restarts the prescaler, so the next counter tick comes a full prescale period later. A counter write takes priority over a tick in the same cycle.
- R10: The event flag is control bit 8. It stays set until a control write clears it. A hardware set in the same cycle as a clearing write wins.
- R11: With period zero the counter stays at zero and every tick sets the flag.
- R12: Control layout: bit0 on, bit1 external source, bit2 gate, bit3 synchronise, bits[5:4] prescale, bit8 flag. All other control bits always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk | input | 1 | External count input, sampled by clk |
| gate_in | input | 1 | Gate for gated mode |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 control, 1 counter, 2 period, 3 none) |
| wr_op | input | 2 | Write operation (replace, clear, set, invert) |
| wr_data | input | CNT_W | Write data / bit mask |
| ctrl_o | output | 16 | Control register contents |
| count_o | output | CNT_W | Counter value |
| period_o | output | CNT_W | Period value |
| evt_o | output | 1 | Event flag (control bit 8) |

## Verification
A register write shows on the outputs one clock after the edge that takes it. An internal or gated tick moves the counter at that same edge. A synchronised external rise reaches the counter at the third edge after ext_clk rises, and an unsynchronised one at the first. The gate-fall flag appears one edge after gate_in is first seen low. The bench drives inputs and samples outputs only at falling clock edges. Before each rising edge it advances a cycle model written from these latencies, then compares every output at the following falling edge, so each expected value is due exactly one edge after the stimulus that causes it.

// File: rtl/prd_timer_pkg.sv
package prd_timer_pkg;

   typedef enum logic [1:0] {
      OP_WRITE = 2'b00,
      OP_CLEAR = 2'b01,
      OP_SET   = 2'b10,
      OP_FLIP  = 2'b11
   } wr_op_e;

   typedef enum logic [1:0] {
      SEL_CTRL   = 2'd0,
      SEL_COUNT  = 2'd1,
      SEL_PERIOD = 2'd2,
      SEL_NONE   = 2'd3
   } wr_sel_e;

   localparam int CTRL_W    = 16;
   localparam int B_ON      = 0;
   localparam int B_EXT     = 1;
   localparam int B_GATE    = 2;
   localparam int B_SYNC    = 3;
   localparam int B_PS_LO   = 4;
   localparam int B_PS_HI   = 5;
   localparam int B_FLAG    = 8;
   localparam logic [CTRL_W-1:0] CTRL_MASK = 16'h013F;

   // prescaler terminal count for each divide code
   function automatic int ps_last(input logic [1:0] code);
      case (code)
         2'b00:   return 0;
         2'b01:   return 7;
         2'b10:   return 63;
         default: return 255;
      endcase
   endfunction

endpackage

// File: rtl/prd_timer_regop.sv
module prd_timer_regop #(
   parameter int W = 16
) (
   input  logic [1:0]   op,
   input  logic [W-1:0] cur,
   input  logic [W-1:0] data,
   output logic [W-1:0] result
);
   import prd_timer_pkg::*;

   generate
      if (W < 1) begin : g_bad_w
         $error("prd_timer_regop: W must be positive");
      end
   endgenerate

   always_comb begin
      case (wr_op_e'(op))
         OP_WRITE: result = data;
         OP_CLEAR: result = cur & ~data;
         OP_SET:   result = cur | data;
         default:  result = cur ^ data;
      endcase
   end
endmodule

// File: rtl/prd_timer_edge_src.sv
module prd_timer_edge_src #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_clk,
   input  logic gate_in,
   input  logic src_ext,
   input  logic sync_en,
   input  logic gate_en,
   output logic raw_tick,
   output logic gate_fall
);
   localparam int MSB = SYNC_STAGES - 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("prd_timer_edge_src: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [MSB:0] sync_q;
   logic         sync_last_q;
   logic         raw_last_q;
   logic         gate_last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q      <= '0;
         sync_last_q <= 1'b0;
         raw_last_q  <= 1'b0;
         gate_last_q <= 1'b0;
      end else begin
         sync_q      <= {sync_q[MSB-1:0], ext_clk};
         sync_last_q <= sync_q[MSB];
         raw_last_q  <= ext_clk;
         gate_last_q <= gate_in;
      end
   end

   logic sync_rise;
   logic direct_rise;
   logic gated_mode;

   assign sync_rise   = sync_q[MSB] & ~sync_last_q;
   assign direct_rise = ext_clk & ~raw_last_q;
   assign gated_mode  = ~src_ext & gate_en;

   always_comb begin
      if (src_ext)         raw_tick = sync_en ? sync_rise : direct_rise;
      else if (gate_en)    raw_tick = gate_in;
      else                 raw_tick = 1'b1;
   end

   assign gate_fall = gated_mode & gate_last_q & ~gate_in;
endmodule

// File: rtl/prd_timer_prescaler.sv
module prd_timer_prescaler #(
   parameter int PS_W = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic       raw_tick,
   input  logic [1:0] ps_code,
   output logic       tick
);
   import prd_timer_pkg::*;

   generate
      if (PS_W < 8) begin : g_bad_ps
         $error("prd_timer_prescaler: PS_W must hold a divide of 256");
      end
   endgenerate

   logic [PS_W-1:0] pre_q;
   logic [PS_W-1:0] last;
   logic            at_last;

   assign last    = PS_W'(ps_last(ps_code));
   assign at_last = (pre_q == last);
   assign tick    = ~restart & raw_tick & at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pre_q <= '0;
      else if (restart)    pre_q <= '0;
      else if (raw_tick)   pre_q <= at_last ? '0 : pre_q + 1'b1;
   end
endmodule

// File: rtl/prd_timer.sv
module prd_timer #(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_clk,
   input  logic             gate_in,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [1:0]       wr_op,
   input  logic [CNT_W-1:0] wr_data,
   output logic [15:0]      ctrl_o,
   output logic [CNT_W-1:0] count_o,
   output logic [CNT_W-1:0] period_o,
   output logic             evt_o
);
   import prd_timer_pkg::*;

   localparam int PS_W = 8;

   generate
      if (CNT_W < CTRL_W) begin : g_bad_cnt
         $error("prd_timer: CNT_W must be at least the control width");
      end
   endgenerate

   logic [CTRL_W-1:0] ctrl_q;
   logic [CNT_W-1:0]  count_q;
   logic [CNT_W-1:0]  period_q;

   logic wr_ctrl, wr_count, wr_period;
   assign wr_ctrl   = wr_en & (wr_sel == SEL_CTRL);
   assign wr_count  = wr_en & (wr_sel == SEL_COUNT);
   assign wr_period = wr_en & (wr_sel == SEL_PERIOD);

   logic on, src_ext, gate_en, sync_en, gated;
   assign on      = ctrl_q[B_ON];
   assign src_ext = ctrl_q[B_EXT];
   assign gate_en = ctrl_q[B_GATE];
   assign sync_en = ctrl_q[B_SYNC];
   assign gated   = ~src_ext & gate_en;

   // write operations
   logic [CTRL_W-1:0] ctrl_op;
   logic [CNT_W-1:0]  count_op;
   logic [CNT_W-1:0]  period_op;

   prd_timer_regop #(.W(CTRL_W)) u_op_ctrl (
      .op(wr_op), .cur(ctrl_q), .data(wr_data[CTRL_W-1:0]), .result(ctrl_op)
   );
   prd_timer_regop #(.W(CNT_W)) u_op_count (
      .op(wr_op), .cur(count_q), .data(wr_data), .result(count_op)
   );
   prd_timer_regop #(.W(CNT_W)) u_op_period (
      .op(wr_op), .cur(period_q), .data(wr_data), .result(period_op)
   );

   // tick generation
   logic raw_tick, gate_fall, tick, pre_restart;
   assign pre_restart = wr_ctrl | wr_count | ~on;

   prd_timer_edge_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
      .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .gate_in(gate_in),
      .src_ext(src_ext), .sync_en(sync_en), .gate_en(gate_en),
      .raw_tick(raw_tick), .gate_fall(gate_fall)
   );

   prd_timer_prescaler #(.PS_W(PS_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .restart(pre_restart), .raw_tick(raw_tick),
      .ps_code(ctrl_q[B_PS_HI:B_PS_LO]), .tick(tick)
   );

   // counter, period match and flag
   logic match, advance, period_evt, hw_set;
   assign match      = (count_q == period_q);
   assign advance    = on & tick & ~wr_count;
   assign period_evt = advance & match & ~gated;
   assign hw_set     = period_evt | (on & gate_fall);

   logic [CTRL_W-1:0] ctrl_d;
   logic [CNT_W-1:0]  count_d;

   always_comb begin
      ctrl_d = ctrl_q;
      if (wr_ctrl) ctrl_d = ctrl_op & CTRL_MASK;
      if (hw_set)  ctrl_d[B_FLAG] = 1'b1;
   end

   always_comb begin
      if (wr_count)     count_d = count_op;
      else if (advance) count_d = match ? '0 : count_q + 1'b1;
      else              count_d = count_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         count_q  <= '0;
         period_q <= '0;
      end else begin
         ctrl_q  <= ctrl_d;
         count_q <= count_d;
         if (wr_period) period_q <= period_op;
      end
   end

   assign ctrl_o   = ctrl_q;
   assign count_o  = count_q;
   assign period_o = period_q;
   assign evt_o    = ctrl_q[B_FLAG];
endmodule

// File: rtl/prd_timer_chk.sv
module prd_timer_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       wr_sel,
   input logic [15:0]      ctrl_o,
   input logic [CNT_W-1:0] count_o,
   input logic [CNT_W-1:0] period_o,
   input logic             evt_o
);
   logic wr_c, wr_n, wr_p;
   assign wr_c = wr_en & (wr_sel == 2'd0);
   assign wr_n = wr_en & (wr_sel == 2'd1);
   assign wr_p = wr_en & (wr_sel == 2'd2);

   a_r7_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_o[0] && !wr_n) |=> $stable(count_o));

   a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_o && !wr_c) |=> evt_o);

   a_r12_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ((ctrl_o & 16'hFEC0) == 16'h0000));

   a_r2_step_or_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |=> (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1
                 || count_o == '0));

   a_r11_zero_period_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (period_o == '0 && count_o == '0 && !wr_n) |=> (count_o == '0));

   a_r8_period_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_p |=> $stable(period_o));
endmodule

bind prd_timer prd_timer_chk #(.CNT_W(CNT_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
   .ctrl_o(ctrl_o), .count_o(count_o), .period_o(period_o), .evt_o(evt_o)
);

// File: tb/prd_timer_tb_top.sv
`timescale 1ns/1ps
module prd_timer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_clk = 1'b0;
   logic        gate_in = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [1:0]  wr_op = 2'd0;
   logic [15:0] wr_data = 16'h0;
   logic [15:0] ctrl_o, count_o, period_o;
   logic        evt_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   prd_timer #(.CNT_W(16), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .gate_in(gate_in),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_op(wr_op), .wr_data(wr_data),
      .ctrl_o(ctrl_o), .count_o(count_o), .period_o(period_o), .evt_o(evt_o)
   );

   // cycle model built from the requirements
   logic [15:0] m_ctrl = 0, m_cnt = 0, m_per = 0;
   int          m_pre = 0;
   logic        m_s0 = 0, m_s1 = 0, m_eq = 0, m_ea = 0, m_gq = 0;

   function automatic logic [15:0] op_apply(input logic [1:0] op,
                                            input logic [15:0] cur, d);
      case (op)
         2'b00:   return d;
         2'b01:   return cur & ~d;
         2'b10:   return cur | d;
         default: return cur ^ d;
      endcase
   endfunction

   function automatic int divide_of(input logic [1:0] code); // R3
      case (code)
         2'b00:   return 1;
         2'b01:   return 8;
         2'b10:   return 64;
         default: return 256;
      endcase
   endfunction

   task automatic model_step();
      logic on, ext, gated, wc, wn, wp, raw, fall, clr, tick, match, hws;
      logic [15:0] nctrl, ncnt;
      int npre, dv;
      on    = m_ctrl[0];
      ext   = m_ctrl[1];
      gated = !m_ctrl[1] && m_ctrl[2];
      wc = wr_en && wr_sel == 2'd0;
      wn = wr_en && wr_sel == 2'd1;
      wp = wr_en && wr_sel == 2'd2;
      if (ext) raw = m_ctrl[3] ? (m_s1 && !m_eq) : (ext_clk && !m_ea); // R5 R6
      else     raw = gated ? gate_in : 1'b1;                              // R4
      fall = gated && m_gq && !gate_in;
      clr  = wc || wn || !on;                                             // R9 R7
      dv   = divide_of(m_ctrl[5:4]);
      tick = 1'b0;
      npre = m_pre;
      if (clr) npre = 0;
      else if (raw) begin
         if (m_pre == dv - 1) begin tick = 1'b1; npre = 0; end
         else npre = m_pre + 1;
      end
      match = (m_cnt == m_per);
      ncnt  = m_cnt;
      if (wn) ncnt = op_apply(wr_op, m_cnt, wr_data);
      else if (on && tick) ncnt = match ? 16'h0 : m_cnt + 16'h1;           // R2 R11
      hws   = (on && tick && match && !gated && !wn) || (on && fall);
      nctrl = wc ? (op_apply(wr_op, m_ctrl, wr_data) & 16'h013F) : m_ctrl; // R12
      if (hws) nctrl[8] = 1'b1;                                            // R10
      if (wp) m_per = op_apply(wr_op, m_per, wr_data);                     // R8
      m_ctrl = nctrl;
      m_cnt  = ncnt;
      m_pre  = npre;
      m_eq = m_s1; m_s1 = m_s0; m_s0 = ext_clk; m_ea = ext_clk; m_gq = gate_in;
   endtask

   task automatic check(input string req, input logic [31:0] act, exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step();
      model_step();
      @(negedge clk);
      check("R2 count vs model", 32'(count_o), 32'(m_cnt));
      check("R8 period vs model", 32'(period_o), 32'(m_per));
      check("R12 control vs model", 32'(ctrl_o), 32'(m_ctrl));
      check("R10 flag vs model", 32'(evt_o), 32'(m_ctrl[8]));
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic wr(input logic [1:0] sel, op, input logic [15:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_op = op; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   initial begin
      int seed;
      seed = $urandom(32'h5EED);
      repeat (3) @(negedge clk);
      check("R1 reset control", 32'(ctrl_o), 32'h0);
      check("R1 reset count", 32'(count_o), 32'h0);
      check("R1 reset period", 32'(period_o), 32'h0);
      check("R1 reset flag", 32'(evt_o), 32'h0);
      rst_n = 1'b1;
      idle(2);

      // R2: period 5, internal, divide 1
      wr(2'd2, 2'b00, 16'd5);
      wr(2'd0, 2'b00, 16'h0001);
      idle(5);
      check("R2 count before match", 32'(count_o), 32'd5);
      check("R2 no flag before match", 32'(evt_o), 32'd0);
      idle(1);
      check("R2 wrap to zero", 32'(count_o), 32'd0);
      check("R2 flag on match", 32'(evt_o), 32'd1);

      // R10: clear alias on the flag bit
      wr(2'd0, 2'b01, 16'h0100);
      check("R10 flag cleared", 32'(evt_o), 32'd0);
      check("R10 control after clear", 32'(ctrl_o), 32'h0001);

      // R3 R9: divide by 8, prescaler restart
      wr(2'd2, 2'b00, 16'hFFFF);
      wr(2'd1, 2'b00, 16'h0000);
      wr(2'd0, 2'b10, 16'h0010);
      idle(7);
      check("R3 divide-8 still zero", 32'(count_o), 32'd0);
      idle(1);
      check("R9 first tick after full period", 32'(count_o), 32'd1);

      // R7: off holds counter
      wr(2'd0, 2'b01, 16'h0001);
      idle(20);
      check("R7 hold while off", 32'(count_o), 32'd1);

      // R5: synchronised external edges, gate ignored
      wr(2'd0, 2'b00, 16'h000B);
      wr(2'd1, 2'b00, 16'h0000);
      for (int p = 0; p < 4; p++) begin
         ext_clk = 1'b1; gate_in = ~gate_in; idle(3);
         ext_clk = 1'b0; idle(3);
      end
      check("R5 one tick per rising edge", 32'(count_o), 32'd4);

      // R6: direct external edges
      wr(2'd0, 2'b00, 16'h0003);
      wr(2'd1, 2'b00, 16'h0000);
      for (int p = 0; p < 3; p++) begin
         ext_clk = 1'b1; idle(1);
         ext_clk = 1'b0; idle(1);
      end
      check("R6 direct edge count", 32'(count_o), 32'd3);

      // R4: gated accumulation and falling-edge flag
      gate_in = 1'b0;
      wr(2'd0, 2'b00, 16'h0005);
      wr(2'd1, 2'b00, 16'h0000);
      gate_in = 1'b1; idle(10);
      check("R4 counts while gate high", 32'(count_o), 32'd10);
      check("R4 no flag while high", 32'(evt_o), 32'd0);
      gate_in = 1'b0; idle(1);
      check("R4 flag on gate fall", 32'(evt_o), 32'd1);
      idle(4);
      check("R4 count frozen gate low", 32'(count_o), 32'd10);
      wr(2'd0, 2'b00, 16'h0005);
      wr(2'd2, 2'b00, 16'd3);
      wr(2'd1, 2'b00, 16'h0000);
      gate_in = 1'b1; idle(8);
      check("R4 match gives no flag", 32'(evt_o), 32'd0);
      gate_in = 1'b0; idle(1);

      // R11: zero period
      wr(2'd0, 2'b00, 16'h0001);
      wr(2'd2, 2'b00, 16'h0000);
      wr(2'd1, 2'b00, 16'h0000);
      idle(3);
      check("R11 count stays zero", 32'(count_o), 32'd0);
      check("R11 flag set", 32'(evt_o), 32'd1);

      // R8: select 3 ignored, invert alias
      wr(2'd3, 2'b10, 16'hFFFF);
      check("R8 sel3 control unchanged", 32'(ctrl_o), 32'h0101);
      check("R8 sel3 period unchanged", 32'(period_o), 32'h0);
      wr(2'd2, 2'b11, 16'h00F0);
      check("R8 invert once", 32'(period_o), 32'h00F0);
      wr(2'd2, 2'b11, 16'h0030);
      check("R8 invert again", 32'(period_o), 32'h00C0);

      // R12: reserved bits read zero
      wr(2'd0, 2'b00, 16'hFFFF);
      check("R12 reserved masked", 32'(ctrl_o), 32'h013F);
      wr(2'd0, 2'b00, 16'h0000);

      // random mix against the model
      for (int c = 0; c < 4000; c++) begin
         logic [1:0] sel;
         logic [15:0] d;
         if ($urandom_range(0, 3) == 0) gate_in = ~gate_in;
         if ($urandom_range(0, 1) == 0) ext_clk = ~ext_clk;
         if ($urandom_range(0, 9) == 0) begin
            sel = 2'($urandom_range(0, 3));
            d   = (sel == 2'd0) ? 16'($urandom) : 16'($urandom_range(0, 40));
            wr(sel, 2'($urandom_range(0, 3)), d);
         end else begin
            step();
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R1 watchdog act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule